// File: doc/BRIEF.md
# Expected-Response Pattern Comparator

This block checks the response of a device under test, one sample at a time, against a stream of expected symbols. Each channel of each sample carries its own expected symbol: the channel must read low, must read high, or is ignored. For every valid sample the block reports which channels disagreed. This report is registered and appears one cycle after the sample.

Around the per-sample check sits a window accumulator. A start pulse opens a compare window and clears the running failure count and the verdict. While the window is open, every valid sample with at least one disagreeing channel adds one to a saturating count. An end pulse closes the window. One cycle later the block raises a result strobe, and the verdict shows pass only if no sample in the window failed. The block holds neither the expected patterns nor the captured data. Both arrive as streams alongside each other.

Top module: `expect_cmp`

## Requirements
- R1: An expected symbol of 2'b00 (expect low) on a channel flags that channel as mismatched when its sample bit is 1, and not when it is 0.
- R2: An expected symbol of 2'b01 (expect high) on a channel flags that channel as mismatched when its sample bit is 0, and not when it is 1.
- R3: An expected symbol with bit 1 set (2'b10 or 2'b11, don't care) never flags its channel, whatever the sample bit.
- R4: `miss_vec` and `miss_vld` show the result for the sample presented in the previous cycle. Bit i of `miss_vec` belongs to channel i, and channel i uses bits [2i+1:2i] of `exp_sym`. When `smp_vld` was low, `miss_vld` is 0 and `miss_vec` is all zeros.
- R5: A `win_start` pulse clears `fail_cnt` and drops `win_pass` to 0. A sample presented in the same cycle belongs to the new window.
- R6: Inside an open window, which runs from the start cycle through the end cycle inclusive, `fail_cnt` rises by exactly one for each valid sample with at least one mismatched channel. It does not change for clean samples, for invalid samples, or for samples outside a window.
- R7: `fail_cnt` saturates at 2^CNT_W-1 and stays there until the next window start.
- R8: `result_vld` is high for the cycle after a `win_end` that closes a window. In that cycle `win_pass` is 1 exactly when no sample of the window failed. `win_pass` holds its value until the next start. A start and an end in the same cycle form a one-sample window.
- R9: A `win_end` while no window is open is ignored: no result strobe, and `win_pass` and `fail_cnt` are unchanged.
- R10: A single channel that receives 0,1,0,0,1,0,1 against expected L,H,X,X,X,L,H over one window yields a pass with a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample and expected symbols are valid this cycle |
| smp_data | input | LANES | Captured sample, one bit per channel |
| exp_sym | input | 2*LANES | Expected symbol per channel: 00 low, 01 high, 1x don't care |
| win_start | input | 1 | Opens a compare window and clears the accumulators |
| win_end | input | 1 | Closes the open window; this cycle's sample is still counted |
| miss_vec | output | LANES | Per-channel mismatch for the previous cycle's sample |
| miss_vld | output | 1 | `miss_vec` belongs to a valid sample |
| fail_cnt | output | CNT_W | Saturating count of failing samples in the current or last window |
| win_pass | output | 1 | Verdict of the last closed window |
| result_vld | output | 1 | One-cycle strobe: `win_pass` has just been updated by a window end |

## Verification
The assertions assume that `win_start` and `win_end` are single-cycle pulses and that `exp_sym` and `smp_data` are known (no X) whenever `smp_vld` is high. A repeated start inside an open window is taken as a restart. The bench drives every control as a one-cycle pulse on the falling edge and never leaves data undefined. The exhaustive sweep covers all 256 symbol combinations of a four-channel build against all 16 data values. The window tests use a 3-bit count so that saturation is reached within ten samples.

// File: rtl/expect_cmp_pkg.sv
package expect_cmp_pkg;

   // Expected-symbol encoding, two bits per channel
   localparam logic [1:0] SYM_LOW  = 2'b00;
   localparam logic [1:0] SYM_HIGH = 2'b01;
   localparam logic [1:0] SYM_DC   = 2'b10;   // any code with bit 1 set

   localparam int unsigned SYM_W = 2;

   // Mismatch of one channel against its expected symbol
   function automatic logic sym_miss(input logic [SYM_W-1:0] sym, input logic bit_in);
      return (sym[1] == 1'b0) && (sym[0] != bit_in);
   endfunction

endpackage

// File: rtl/expect_cmp_lane.sv
module expect_cmp_lane
   import expect_cmp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic             bit_in,
   input  logic [SYM_W-1:0] sym,
   output logic             miss_now,
   output logic             miss_q
);

   assign miss_now = smp_vld & sym_miss(sym, bit_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) miss_q <= 1'b0;
      else        miss_q <= miss_now;
   end

   // R3: don't-care never flags
   p_dc_never_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && sym[1]) |=> !miss_q);

   // R1: expect-low read high flags
   p_low_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && sym == SYM_LOW && bit_in) |=> miss_q);

   // R2: expect-high read low flags
   p_high_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && sym == SYM_HIGH && !bit_in) |=> miss_q);

endmodule

// File: rtl/expect_cmp_window.sv
module expect_cmp_window #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic             any_miss,
   input  logic             win_start,
   input  logic             win_end,
   output logic [CNT_W-1:0] fail_cnt,
   output logic             win_pass,
   output logic             result_vld
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             in_win;
   logic             open_eff;
   logic             hit;
   logic             ending;
   logic [CNT_W-1:0] cnt_base;
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      open_eff = win_start | in_win;
      hit      = smp_vld & any_miss & open_eff;
      ending   = win_end & open_eff;
      cnt_base = win_start ? '0 : fail_cnt;
      cnt_nxt  = (hit && (cnt_base != CNT_MAX)) ? cnt_base + CNT_W'(1) : cnt_base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_win     <= 1'b0;
         fail_cnt   <= '0;
         win_pass   <= 1'b0;
         result_vld <= 1'b0;
      end else begin
         in_win     <= open_eff & ~win_end;
         fail_cnt   <= cnt_nxt;
         result_vld <= ending;
         if (ending)         win_pass <= (cnt_nxt == '0);
         else if (win_start) win_pass <= 1'b0;
      end
   end

   // R6: count moves by at most one outside a restart
   p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !win_start |=> (fail_cnt == $past(fail_cnt)) || (fail_cnt == $past(fail_cnt) + CNT_W'(1)));

   // R7: saturated count holds
   p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_start && fail_cnt == CNT_MAX) |=> fail_cnt == CNT_MAX);

   // R5: start clears the verdict and the count
   p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start && !win_end) |=> (fail_cnt <= CNT_W'(1)) && !win_pass);

   // R8: a pass verdict comes with a zero count
   p_pass_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (result_vld && win_pass) |-> fail_cnt == '0);

   // R9: stray end gives no strobe
   p_stray_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && !win_start && !in_win) |=> !result_vld);

endmodule

// File: rtl/expect_cmp.sv
module expect_cmp
   import expect_cmp_pkg::*;
#(
   parameter int unsigned LANES = 8,
   parameter int unsigned CNT_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_vld,
   input  logic [LANES-1:0]       smp_data,
   input  logic [SYM_W*LANES-1:0] exp_sym,
   input  logic                   win_start,
   input  logic                   win_end,
   output logic [LANES-1:0]       miss_vec,
   output logic                   miss_vld,
   output logic [CNT_W-1:0]       fail_cnt,
   output logic                   win_pass,
   output logic                   result_vld
);

   if (LANES < 1) begin : g_bad_lanes
      $error("expect_cmp: LANES must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("expect_cmp: CNT_W must be at least 1");
   end

   logic [LANES-1:0] miss_now;
   logic             any_miss;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      expect_cmp_lane u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .smp_vld  (smp_vld),
         .bit_in   (smp_data[i]),
         .sym      (exp_sym[SYM_W*i +: SYM_W]),
         .miss_now (miss_now[i]),
         .miss_q   (miss_vec[i])
      );
   end

   assign any_miss = |miss_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) miss_vld <= 1'b0;
      else        miss_vld <= smp_vld;
   end

   expect_cmp_window #(.CNT_W(CNT_W)) u_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_vld    (smp_vld),
      .any_miss   (any_miss),
      .win_start  (win_start),
      .win_end    (win_end),
      .fail_cnt   (fail_cnt),
      .win_pass   (win_pass),
      .result_vld (result_vld)
   );

   // R4: no flags without a valid sample
   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> (miss_vec == '0) && !miss_vld);

endmodule

// File: tb/expect_cmp_tb_top.sv
`timescale 1ns/1ps
module expect_cmp_tb_top;

   localparam int N  = 4;
   localparam int CW = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           smp_vld = 1'b0;
   logic [N-1:0]   smp_data = '0;
   logic [2*N-1:0] exp_sym = '0;
   logic           win_start = 1'b0;
   logic           win_end = 1'b0;
   logic [N-1:0]   miss_vec;
   logic           miss_vld;
   logic [CW-1:0]  fail_cnt;
   logic           win_pass;
   logic           result_vld;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   expect_cmp #(.LANES(N), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .exp_sym(exp_sym), .win_start(win_start), .win_end(win_end),
      .miss_vec(miss_vec), .miss_vld(miss_vld), .fail_cnt(fail_cnt),
      .win_pass(win_pass), .result_vld(result_vld)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one cycle of inputs; returns at the falling edge after the capturing edge
   task automatic cyc(input logic v, input logic [N-1:0] d, input logic [2*N-1:0] s,
                      input logic st, input logic en);
      smp_vld = v; smp_data = d; exp_sym = s; win_start = st; win_end = en;
      @(negedge clk);
   endtask

   function automatic int exp_miss(input int s, input int d);
      int m = 0;
      for (int i = 0; i < N; i++) begin
         int c = (s >> (2*i)) & 3;
         if (c < 2 && ((c & 1) != ((d >> i) & 1))) m |= (1 << i);
      end
      return m;
   endfunction

   // lane 0 symbol, other lanes don't care (2'b10)
   function automatic logic [2*N-1:0] sym0(input logic [1:0] c);
      return {{(N-1){2'b10}}, c};
   endfunction

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R4 reset miss_vld", miss_vld, 0);
      chk("R4 reset miss_vec", miss_vec, 0);
      chk("R6 reset fail_cnt", fail_cnt, 0);
      chk("R8 reset result_vld", result_vld, 0);

      // R1 R2 R3 R4: exhaustive symbol x data sweep, no window
      for (int s = 0; s < 256; s++) begin
         for (int d = 0; d < 16; d++) begin
            cyc(1'b1, N'(d), 8'(s), 1'b0, 1'b0);
            chk("R1 R2 R3 miss_vec", miss_vec, exp_miss(s, d));
            chk("R4 miss_vld", miss_vld, 1);
         end
      end
      chk("R6 no count outside window", fail_cnt, 0);

      // R4: invalid sample with mismatching pattern
      cyc(1'b0, 4'hF, 8'h00, 1'b0, 1'b0);
      chk("R4 idle miss_vec", miss_vec, 0);
      chk("R4 idle miss_vld", miss_vld, 0);

      // R6 R8: window of five, two failing samples, one invalid mismatch
      cyc(1'b1, 4'h0, 8'h00, 1'b1, 1'b0);       // clean, start
      chk("R5 start count", fail_cnt, 0);
      chk("R5 start pass", win_pass, 0);
      cyc(1'b1, 4'h3, 8'h00, 1'b0, 1'b0);       // two channels fail
      chk("R6 multi-channel counts once", fail_cnt, 1);
      cyc(1'b0, 4'hF, 8'h00, 1'b0, 1'b0);       // invalid
      chk("R6 invalid not counted", fail_cnt, 1);
      cyc(1'b1, 4'hA, 8'hAA, 1'b0, 1'b0);       // all don't care
      chk("R6 clean not counted", fail_cnt, 1);
      cyc(1'b1, 4'h0, 8'h55, 1'b0, 1'b1);       // fail on end cycle
      chk("R6 end-cycle sample counted", fail_cnt, 2);
      chk("R8 result strobe", result_vld, 1);
      chk("R8 fail verdict", win_pass, 0);
      cyc(1'b1, 4'hF, 8'h00, 1'b0, 1'b0);       // after window
      chk("R8 strobe one cycle", result_vld, 0);
      chk("R6 after window not counted", fail_cnt, 2);

      // R5 R7: restart and saturate
      cyc(1'b1, 4'h1, 8'h00, 1'b1, 1'b0);
      chk("R5 restart clears count", fail_cnt, 1);
      for (int k = 2; k <= 10; k++) begin
         cyc(1'b1, 4'h1, 8'h00, 1'b0, 1'b0);
         chk("R7 saturating count", fail_cnt, (k > 7) ? 7 : k);
      end
      cyc(1'b1, 4'h1, 8'h00, 1'b0, 1'b1);
      chk("R7 saturated at end", fail_cnt, 7);
      chk("R8 saturated verdict", win_pass, 0);
      chk("R8 saturated strobe", result_vld, 1);

      // R10: 0100101 against L H X X X L H on lane 0
      cyc(1'b1, 4'h0, sym0(2'b00), 1'b1, 1'b0);
      chk("R5 start clears saturated count", fail_cnt, 0);
      cyc(1'b1, 4'h1, sym0(2'b01), 1'b0, 1'b0);
      cyc(1'b1, 4'h0, sym0(2'b10), 1'b0, 1'b0);
      cyc(1'b1, 4'h0, sym0(2'b11), 1'b0, 1'b0);
      cyc(1'b1, 4'h1, sym0(2'b10), 1'b0, 1'b0);
      cyc(1'b1, 4'h0, sym0(2'b00), 1'b0, 1'b0);
      cyc(1'b1, 4'h1, sym0(2'b01), 1'b0, 1'b1);
      chk("R10 result strobe", result_vld, 1);
      chk("R10 pass verdict", win_pass, 1);
      chk("R10 zero count", fail_cnt, 0);

      // R9: stray end keeps verdict; mismatch outside window ignored
      cyc(1'b1, 4'hF, 8'h00, 1'b0, 1'b1);
      chk("R9 stray end no strobe", result_vld, 0);
      chk("R9 stray end keeps pass", win_pass, 1);
      chk("R9 stray end keeps count", fail_cnt, 0);
      cyc(1'b0, 4'h0, 8'h00, 1'b0, 1'b0);
      chk("R8 pass held", win_pass, 1);

      // R8: start and end in one cycle, failing sample
      cyc(1'b1, 4'h8, 8'h00, 1'b1, 1'b1);
      chk("R8 one-sample window strobe", result_vld, 1);
      chk("R8 one-sample window verdict", win_pass, 0);
      chk("R8 one-sample window count", fail_cnt, 1);
      cyc(1'b1, 4'h8, 8'h00, 1'b0, 1'b0);
      chk("R6 closed one-sample window", fail_cnt, 1);
      chk("R8 one-sample strobe ends", result_vld, 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule